// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter reached through a small 32-bit register window. The bus side uses single-cycle read and write strobes, and only the low 16 bits of each word carry meaning. The counter does not run from the core clock. It moves one step on each pulse of an external tick strobe, and each step stands for 10 ms. A programmable 15-bit timeout sets the reload value, so the longest period is roughly 327 s.

Every control action takes a specific 16-bit key written to a specific register: feeding, restarting, clearing the status and disabling. Disabling takes two keys written back to back to two different registers. Status is read back as 16-bit code words rather than single flag bits.

One tick before expiry the block sets a warning event. The event drives an interrupt through a mask. When the count reaches zero the block pulses a reset request for one cycle, records the timeout in a sticky status and reloads the counter. A debug-mode input can freeze counting unless software has allowed the watchdog to run during debug.

Top module: `keylock_wdog`

## Requirements
- R1: After reset the watchdog is stopped. The timeout and the count both hold 6000. Status at byte offset 0x10 reads 0x0000, the stopped code 0xDABE reads at 0x0C, the mask at 0x24 reads 0, the event at 0x20 reads 0, the debug control at 0x18 reads 0, and `irq` and `rst_req` are low.
- R2: A write of 0xFEED to offset 0x00 loads the count from the timeout value, whether the watchdog is running or stopped. Any other value written to 0x00 leaves the count unchanged.
- R3: The timeout register at offset 0x04 keeps only bits 14:0 of a write. Writing 0xFFFF reads back 0x7FFF.
- R4: A write of 0xACED to offset 0x1C starts a stopped watchdog, and any other value there is ignored. Offset 0x0C reads 0x0000 while running and 0xDABE while stopped.
- R5: The watchdog stops only when 0x2BAD is written to offset 0x08 and the very next bus write puts 0xCAFE at offset 0x0C. Writing 0xCAFE without the armed first key does nothing. Any other write in between consumes the first key.
- R6: While running, each tick pulse lowers the count by one. While stopped, ticks leave the count unchanged and no reset request is raised. Bits 14:0 of offset 0x14 read the count.
- R7: A tick that finds the count at 1 or 0 pulses `rst_req` high for exactly one cycle and reloads the count from the timeout. It also sets the status at 0x10 to read 0xCFE8. That status stays set until 0xE8B4 is written to 0x10, and other values written there are ignored.
- R8: A tick that moves the count from 2 to 1 sets the event bit (bit 0 at 0x20). Writing 1 to bit 0 of 0x20 clears it. Writing 1 to bit 0 of 0x28 sets it. `irq` equals the event AND the mask bit 0 at 0x24.
- R9: Bit 1 of offset 0x18 reads the `dbg_mode` input. While `dbg_mode` is high, ticks are counted only if bit 0 of 0x18 is set.
- R10: A read of 0x14 in a cycle where the count changes (a tick that is counted, or a feed) returns bit 15 set together with the count as it stood before the change. Otherwise bit 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe; data is valid the cycle after |
| addr | input | ADDR_W (6) | Byte address of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, registered |
| tick | input | 1 | One-cycle 10 ms step strobe |
| dbg_mode | input | 1 | Debug-mode indication |
| irq | output | 1 | Warning interrupt |
| rst_req | output | 1 | One-cycle reset request at expiry |

## Verification
The assertions assume that `tick` and the bus strobes are synchronous to `clk` and last one cycle each. They also assume that the address bus is word aligned, so bits 1:0 are ignored. The bench drives every strobe for exactly one cycle from the falling edge, issues one bus access at a time, and lines tick pulses up with reads only where the update flag of R10 is the thing being checked. Timeouts are kept to a few ticks, so expiry, the warning step and the frozen-count cases are all reached within a short run.

// File: rtl/keylock_wdog_pkg.sv
package keylock_wdog_pkg;

   localparam int KEY_W = 16;

   // word index of each register; software decodes these positions
   typedef enum logic [3:0] {
      IX_FEED  = 4'd0,
      IX_TMO   = 4'd1,
      IX_DIS1  = 4'd2,
      IX_DIS2  = 4'd3,
      IX_STAT  = 4'd4,
      IX_CNT   = 4'd5,
      IX_DBG   = 4'd6,
      IX_RSTRT = 4'd7,
      IX_EVT   = 4'd8,
      IX_MASK  = 4'd9,
      IX_FORCE = 4'd10
   } reg_ix_e;

   localparam int NUM_REGS = 11;

   localparam logic [KEY_W-1:0] KEY_FEED    = 16'hFEED;
   localparam logic [KEY_W-1:0] KEY_DIS1    = 16'h2BAD;
   localparam logic [KEY_W-1:0] KEY_DIS2    = 16'hCAFE;
   localparam logic [KEY_W-1:0] KEY_RESTART = 16'hACED;
   localparam logic [KEY_W-1:0] KEY_CLEAR   = 16'hE8B4;

   localparam logic [KEY_W-1:0] CODE_STOPPED = 16'hDABE;
   localparam logic [KEY_W-1:0] CODE_EXPIRED = 16'hCFE8;

   typedef struct packed {
      logic feed_go;
      logic tmo_wr;
      logic dis1_key;
      logic dis2_key;
      logic restart_go;
      logic clr_go;
      logic dbg_wr;
      logic ack;
      logic mask_wr;
      logic force_set;
      logic any_wr;
   } wr_strobes_t;

endpackage

// File: rtl/keylock_wdog_decode.sv
module keylock_wdog_decode
   import keylock_wdog_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 15
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output wr_strobes_t       stb,
   output logic [CNT_W-1:0]  wval,
   output logic              wbit0
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0]    idx;
   logic [NUM_REGS-1:0] sel;
   logic [KEY_W-1:0]    key;
   logic                unused_bits;

   assign idx   = addr[ADDR_W-1:2];
   assign key   = wdata[KEY_W-1:0];
   assign wval  = wdata[CNT_W-1:0];
   assign wbit0 = wdata[0];
   assign unused_bits = ^{wdata[DATA_W-1:KEY_W], addr[1:0]};

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign sel[i] = wr_en && (idx == IDX_W'(i));
   end

   always_comb begin
      stb            = '0;
      stb.any_wr     = wr_en;
      stb.feed_go    = sel[IX_FEED]  && (key == KEY_FEED);
      stb.tmo_wr     = sel[IX_TMO];
      stb.dis1_key   = sel[IX_DIS1]  && (key == KEY_DIS1);
      stb.dis2_key   = sel[IX_DIS2]  && (key == KEY_DIS2);
      stb.restart_go = sel[IX_RSTRT] && (key == KEY_RESTART);
      stb.clr_go     = sel[IX_STAT]  && (key == KEY_CLEAR);
      stb.dbg_wr     = sel[IX_DBG];
      stb.ack        = sel[IX_EVT]   && wdata[0];
      stb.mask_wr    = sel[IX_MASK];
      stb.force_set  = sel[IX_FORCE] && wdata[0];
   end

endmodule

// File: rtl/keylock_wdog_timer.sv
module keylock_wdog_timer
   import keylock_wdog_pkg::*;
#(
   parameter int CNT_W           = 15,
   parameter int DEFAULT_TIMEOUT = 6000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wr_strobes_t      stb,
   input  logic [CNT_W-1:0] wval,
   input  logic             wbit0,
   input  logic             tick,
   input  logic             dbg_mode,
   output logic [CNT_W-1:0] tmo_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             run_q,
   output logic             arm_q,
   output logic             sticky_q,
   output logic             dbg_en_q,
   output logic             upd,
   output logic             warn,
   output logic             rst_req
);
   localparam logic [CNT_W-1:0] RST_TMO = CNT_W'(DEFAULT_TIMEOUT);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

   logic cnt_en;
   logic expire;

   assign cnt_en = run_q && tick && (!dbg_mode || dbg_en_q);
   assign upd    = stb.feed_go || cnt_en;
   assign expire = cnt_en && !stb.feed_go && (cnt_q <= ONE);
   assign warn   = cnt_en && !stb.feed_go && (cnt_q == TWO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q <= RST_TMO;
      end else if (stb.tmo_wr) begin
         tmo_q <= wval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_TMO;
      end else if (stb.feed_go || expire) begin
         cnt_q <= tmo_q;
      end else if (cnt_en) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (stb.dis2_key && arm_q) begin
            run_q <= 1'b0;
         end else if (stb.restart_go) begin
            run_q <= 1'b1;
         end
         if (stb.any_wr) begin
            arm_q <= stb.dis1_key;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
         rst_req  <= 1'b0;
         dbg_en_q <= 1'b0;
      end else begin
         rst_req <= expire;
         if (expire) begin
            sticky_q <= 1'b1;
         end else if (stb.clr_go) begin
            sticky_q <= 1'b0;
         end
         if (stb.dbg_wr) begin
            dbg_en_q <= wbit0;
         end
      end
   end

endmodule

// File: rtl/keylock_wdog_irq.sv
module keylock_wdog_irq
   import keylock_wdog_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  wr_strobes_t stb,
   input  logic        wbit0,
   input  logic        warn,
   output logic        evt_q,
   output logic        mask_q,
   output logic        irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         if (warn || stb.force_set) begin
            evt_q <= 1'b1;
         end else if (stb.ack) begin
            evt_q <= 1'b0;
         end
         if (stb.mask_wr) begin
            mask_q <= wbit0;
         end
      end
   end

   assign irq = evt_q && mask_q;

endmodule

// File: rtl/keylock_wdog_rdmux.sv
module keylock_wdog_rdmux
   import keylock_wdog_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 15,
   parameter bit READ_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  tmo_q,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              upd,
   input  logic              run_q,
   input  logic              sticky_q,
   input  logic              dbg_en_q,
   input  logic              dbg_mode,
   input  logic              evt_q,
   input  logic              mask_q,
   output logic [DATA_W-1:0] rdata
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0]  idx;
   logic [KEY_W-1:0]  field;
   logic [DATA_W-1:0] word;
   logic              unused_lo;

   assign idx       = addr[ADDR_W-1:2];
   assign unused_lo = ^addr[1:0];

   always_comb begin
      field = '0;
      case (idx)
         IDX_W'(IX_TMO):  field = KEY_W'(tmo_q);
         IDX_W'(IX_DIS2): field = run_q ? '0 : CODE_STOPPED;
         IDX_W'(IX_STAT): field = sticky_q ? CODE_EXPIRED : '0;
         IDX_W'(IX_CNT):  field = {upd, cnt_q};
         IDX_W'(IX_DBG):  field = KEY_W'({dbg_mode, dbg_en_q});
         IDX_W'(IX_EVT):  field = KEY_W'(evt_q);
         IDX_W'(IX_MASK): field = KEY_W'(mask_q);
         default:         field = '0;
      endcase
   end

   assign word = DATA_W'(field);

   if (READ_PIPE) begin : g_pipe
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_q <= '0;
         end else if (rd_en) begin
            rdata_q <= word;
         end
      end
      assign rdata = rdata_q;
   end else begin : g_comb
      logic unused_rd;
      assign unused_rd = ^{clk, rst_n, rd_en};
      assign rdata     = word;
   end

endmodule

// File: rtl/keylock_wdog.sv
module keylock_wdog
   import keylock_wdog_pkg::*;
#(
   parameter int ADDR_W          = 6,
   parameter int DATA_W          = 32,
   parameter int CNT_W           = 15,
   parameter int DEFAULT_TIMEOUT = 6000,
   parameter bit READ_PIPE       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tick,
   input  logic              dbg_mode,
   output logic              irq,
   output logic              rst_req
);
   if (ADDR_W < 6) begin : g_err_addr
      $error("ADDR_W must cover eleven word registers");
   end
   if (CNT_W >= KEY_W) begin : g_err_cnt
      $error("CNT_W must leave bit 15 free for the update flag");
   end
   if (DATA_W < KEY_W) begin : g_err_data
      $error("DATA_W must hold a 16-bit key");
   end
   if (DEFAULT_TIMEOUT < 1 || DEFAULT_TIMEOUT >= (1 << CNT_W)) begin : g_err_def
      $error("DEFAULT_TIMEOUT must fit in CNT_W bits and be nonzero");
   end

   wr_strobes_t      stb;
   logic [CNT_W-1:0] wval;
   logic             wbit0;
   logic [CNT_W-1:0] tmo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             arm_q;
   logic             sticky_q;
   logic             dbg_en_q;
   logic             upd;
   logic             warn;
   logic             evt_q;
   logic             mask_q;

   keylock_wdog_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_decode (
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .stb   (stb),
      .wval  (wval),
      .wbit0 (wbit0)
   );

   keylock_wdog_timer #(
      .CNT_W           (CNT_W),
      .DEFAULT_TIMEOUT (DEFAULT_TIMEOUT)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (stb),
      .wval     (wval),
      .wbit0    (wbit0),
      .tick     (tick),
      .dbg_mode (dbg_mode),
      .tmo_q    (tmo_q),
      .cnt_q    (cnt_q),
      .run_q    (run_q),
      .arm_q    (arm_q),
      .sticky_q (sticky_q),
      .dbg_en_q (dbg_en_q),
      .upd      (upd),
      .warn     (warn),
      .rst_req  (rst_req)
   );

   keylock_wdog_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (stb),
      .wbit0  (wbit0),
      .warn   (warn),
      .evt_q  (evt_q),
      .mask_q (mask_q),
      .irq    (irq)
   );

   keylock_wdog_rdmux #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .READ_PIPE (READ_PIPE)
   ) u_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .addr     (addr),
      .tmo_q    (tmo_q),
      .cnt_q    (cnt_q),
      .upd      (upd),
      .run_q    (run_q),
      .sticky_q (sticky_q),
      .dbg_en_q (dbg_en_q),
      .dbg_mode (dbg_mode),
      .evt_q    (evt_q),
      .mask_q   (mask_q),
      .rdata    (rdata)
   );

endmodule

// File: rtl/keylock_wdog_chk.sv
module keylock_wdog_chk
   import keylock_wdog_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              irq,
   input logic              rst_req,
   input logic              run_q,
   input logic              arm_q,
   input logic              sticky_q,
   input logic              mask_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  tmo_q
);
   localparam int IDX_W = ADDR_W - 2;

   logic clr_wr;
   logic dis2_wr;
   logic feed_wr;

   assign clr_wr  = wr_en && (addr[ADDR_W-1:2] == IDX_W'(IX_STAT)) && (wdata[KEY_W-1:0] == KEY_CLEAR);
   assign dis2_wr = wr_en && (addr[ADDR_W-1:2] == IDX_W'(IX_DIS2)) && (wdata[KEY_W-1:0] == KEY_DIS2);
   assign feed_wr = wr_en && (addr[ADDR_W-1:2] == IDX_W'(IX_FEED)) && (wdata[KEY_W-1:0] == KEY_FEED);

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R7

   AST_REQ_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> sticky_q); // R7

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_q && !clr_wr |=> sticky_q); // R7

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> mask_q); // R8

   AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> !rst_req); // R6

   AST_STOP_NEEDS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && !(dis2_wr && arm_q) |=> run_q); // R5

   AST_FEED_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      feed_wr |=> cnt_q == $past(tmo_q)); // R2

endmodule

bind keylock_wdog keylock_wdog_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .irq      (irq),
   .rst_req  (rst_req),
   .run_q    (run_q),
   .arm_q    (arm_q),
   .sticky_q (sticky_q),
   .mask_q   (mask_q),
   .cnt_q    (cnt_q),
   .tmo_q    (tmo_q)
);

// File: tb/keylock_wdog_test.sv
module keylock_wdog_test;

   localparam int A_FEED = 'h00, A_TMO = 'h04, A_DIS1 = 'h08, A_DIS2 = 'h0C,
                  A_STAT = 'h10, A_CNT = 'h14, A_DBG = 'h18, A_RSTRT = 'h1C,
                  A_EVT = 'h20, A_MASK = 'h24, A_FORCE = 'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        tick = 1'b0;
   logic        dbg_mode = 1'b0;
   logic        irq;
   logic        rst_req;

   int    errors = 0;
   int    checks = 0;
   int    rq_cnt = 0;
   bit    done = 1'b0;
   int    exp_q[$];
   string tag_q[$];
   logic  mon_rd;

   always #10 clk = ~clk;

   keylock_wdog uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .tick     (tick),
      .dbg_mode (dbg_mode),
      .irq      (irq),
      .rst_req  (rst_req)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: compares read data the cycle after each read strobe
   always @(posedge clk) begin
      mon_rd = rd_en;
      #2;
      if (rst_req) rq_cnt++;
      if (mon_rd) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "scoreboard empty", int'(rdata), 0);
         end else begin
            chk(rdata == 32'(exp_q[0]), tag_q[0], int'(rdata), exp_q[0]);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   task automatic wr(input int a, input int d);
      addr = 6'(a); wdata = 32'(d); wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, input int exp, input string tag);
      exp_q.push_back(exp); tag_q.push_back(tag);
      addr = 6'(a); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_tick(input int a, input int exp, input string tag);
      exp_q.push_back(exp); tag_q.push_back(tag);
      addr = 6'(a); rd_en = 1'b1; tick = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; tick = 1'b0;
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog timer expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_STAT, 'h0000, "R1 status");
      rd(A_DIS2, 'hDABE, "R1 stopped code");
      rd(A_TMO, 6000, "R1 timeout");
      rd(A_MASK, 0, "R1 mask");
      rd(A_EVT, 0, "R1 event");
      rd(A_DBG, 0, "R1 debug ctl");
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);
      chk(rst_req == 1'b0, "R1 rst_req", int'(rst_req), 0);

      // R6 stopped: ticks ignored
      tk(3);
      rd(A_CNT, 6000, "R6 stopped count");

      // R3 timeout width
      wr(A_TMO, 'hFFFF);
      rd(A_TMO, 'h7FFF, "R3 mask");
      wr(A_TMO, 3);
      rd(A_TMO, 3, "R3 value");

      // R2 feed key
      wr(A_FEED, 'h1234);
      rd(A_CNT, 6000, "R2 wrong key");
      wr(A_FEED, 'hFEED);
      rd(A_CNT, 3, "R2 feed");

      // R4 restart key
      wr(A_RSTRT, 'h1111);
      rd(A_DIS2, 'hDABE, "R4 wrong key");
      wr(A_RSTRT, 'hACED);
      rd(A_DIS2, 'h0000, "R4 running code");

      // R10 update flag, then R6 decrement
      rd_tick(A_CNT, 'h8003, "R10 update flag");
      rd(A_CNT, 2, "R6 decrement");

      // R8 warning event
      tk(1);
      rd(A_EVT, 1, "R8 warn event");
      chk(irq == 1'b0, "R8 masked irq", int'(irq), 0);
      wr(A_MASK, 1);
      chk(irq == 1'b1, "R8 unmasked irq", int'(irq), 1);
      rd(A_CNT, 1, "R8 count one");

      // R7 expiry
      tk(1);
      chk(rq_cnt == 1, "R7 reset pulse", rq_cnt, 1);
      @(negedge clk);
      chk(rst_req == 1'b0, "R7 pulse width", int'(rst_req), 0);
      rd(A_CNT, 3, "R7 reload");
      rd(A_STAT, 'hCFE8, "R7 expired code");
      wr(A_EVT, 1);
      chk(irq == 1'b0, "R8 ack", int'(irq), 0);
      wr(A_STAT, 'h1111);
      rd(A_STAT, 'hCFE8, "R7 wrong clear key");
      wr(A_STAT, 'hE8B4);
      rd(A_STAT, 'h0000, "R7 cleared");

      // R5 two-key stop
      wr(A_DIS2, 'hCAFE);
      rd(A_DIS2, 'h0000, "R5 unarmed");
      wr(A_DIS1, 'h2BAD);
      wr(A_TMO, 3);
      wr(A_DIS2, 'hCAFE);
      rd(A_DIS2, 'h0000, "R5 consumed key");
      wr(A_DIS1, 'h2BAD);
      wr(A_DIS2, 'hCAFE);
      rd(A_DIS2, 'hDABE, "R5 stopped");
      tk(5);
      rd(A_CNT, 3, "R6 frozen after stop");
      chk(rq_cnt == 1, "R6 no request when stopped", rq_cnt, 1);

      // R9 debug override
      wr(A_RSTRT, 'hACED);
      dbg_mode = 1'b1;
      rd(A_DBG, 2, "R9 debug input");
      tk(1);
      rd(A_CNT, 3, "R9 frozen in debug");
      wr(A_DBG, 1);
      rd(A_DBG, 3, "R9 allow bit");
      tk(1);
      rd(A_CNT, 2, "R9 counts when allowed");
      dbg_mode = 1'b0;
      wr(A_DBG, 0);
      tk(1);
      rd(A_CNT, 1, "R9 normal count");
      rd(A_EVT, 1, "R8 warn again");
      wr(A_EVT, 1);
      rd(A_EVT, 0, "R8 ack clears");

      // R8 force
      wr(A_FORCE, 1);
      chk(irq == 1'b1, "R8 forced irq", int'(irq), 1);
      wr(A_EVT, 1);
      chk(irq == 1'b0, "R8 forced ack", int'(irq), 0);
      wr(A_MASK, 0);
      wr(A_FORCE, 1);
      chk(irq == 1'b0, "R8 forced masked", int'(irq), 0);
      rd(A_EVT, 1, "R8 forced event");

      // R2 feed while running
      wr(A_FEED, 'hFEED);
      rd(A_CNT, 3, "R2 feed running");

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule